// File: doc/BRIEF.md
# Pulse Feature Extractor

This block takes a stream of baseline-subtracted waveform samples from one digitizer channel and reduces each acquisition window to one compact record. It does not forward the raw samples. The record carries four results:

- **Charge:** the signed sum of the samples inside a programmable integration sub-window.
- **Crossing time:** the sample index at which the signal first rises above a fixed threshold.
- **Time over threshold:** how long that first excursion stays above the threshold.
- **Pile-up flag:** set when the first difference of the signal changes from rising to falling at two or more places above the threshold.

A programmable dead band on the first difference keeps small noise ripples from being counted as peaks.

Samples arrive on a valid/ready stream, and a marker on the last sample closes the window. One record is produced per window, on a second valid/ready stream. The block holds only one pending record. While that record waits, the input is back-pressured: in_ready stays low until the record is taken. A downstream stall therefore stops sample intake and never drops a record. Threshold, dead band and integration sub-window are plain configuration pins. They must stay stable for the whole window.

Top module: `pulse_feature_unit`

## Requirements
- R1: A sample is taken on a rising clock edge when in_valid and in_ready are both 1. in_ready is 1 exactly when no record is pending. The record becomes valid on the cycle after the beat with in_last=1 is taken. The record stays valid and unchanged until it is taken on an edge with res_ready=1.
- R2: res_charge is the two's-complement sum of every sample whose index i meets cfg_win_start <= i < cfg_win_start + cfg_win_len. Index 0 is the first sample of the window. If cfg_win_len=0, res_charge is 0.
- R3: res_tcross is the index of the first sample that is strictly greater than cfg_thr, compared as signed values. A sample equal to cfg_thr does not count as a crossing.
- R4: res_tot counts the consecutive samples above cfg_thr, starting at the crossing sample and ending before the first later sample that is less than or equal to cfg_thr.
- R5: If no sample exceeds cfg_thr, res_nohit is 1 and res_tcross, res_tot and res_ovf are all 0. Otherwise res_nohit is 0.
- R6: If the first excursion above threshold is still running at the last sample, res_ovf is 1 and res_tot counts up to and including the last sample. Otherwise res_ovf is 0.
- R7: The step at sample n is d = x[n] - x[n-1]. A peak is counted at sample n when all three of these hold: d < -cfg_deadband; the most recent step with |d| > cfg_deadband was rising; and x[n-1] > cfg_thr. res_pileup is 1 when two or more peaks are counted in the window.
- R8: A step with |d| <= cfg_deadband changes neither the remembered slope direction nor the peak count.
- R9: After reset, in_ready is 1 and res_valid is 0.
- R10: Each window starts from a cleared state. No result depends on samples from an earlier window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample beat valid |
| in_ready | output | 1 | Block accepts a sample |
| in_sample | input | W | Signed baseline-subtracted sample |
| in_last | input | 1 | Beat is the last sample of the window |
| cfg_thr | input | W | Signed hit threshold |
| cfg_deadband | input | W | Unsigned slope dead band |
| cfg_win_start | input | CW | First sample index of the integration sub-window |
| cfg_win_len | input | CW | Length of the integration sub-window in samples |
| res_valid | output | 1 | Result record valid |
| res_ready | input | 1 | Consumer takes the record |
| res_charge | output | AW | Signed sub-window integral |
| res_tcross | output | CW | Index of the first threshold crossing |
| res_tot | output | CW | Time over threshold in samples |
| res_pileup | output | 1 | Two or more peaks above threshold |
| res_nohit | output | 1 | No sample above threshold |
| res_ovf | output | 1 | Excursion still above threshold at window end |

## Verification
The main function is exercised with several kinds of input pattern, and each one separates different faults:

- **Single isolated pulse:** fixes the crossing index, the width and the charge.
- **Two well-separated pulses:** tell a real pile-up from one pulse.
- **Baseline-only windows:** confirm the no-hit zeroing.
- **Pulse cut off at the window end:** exposes the overflow clip.
- **Staircase ramp with small dips, run at two dead-band settings:** separates noise ripple from true extrema.
- **Sample exactly at threshold:** checks strict comparison.
- **Narrow and empty integration sub-windows:** check the index bounds.

Randomly shaped windows with random input gaps and output stalls then mix all of these. The stalls also check the hold-and-back-pressure rule.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [1:0] {
    SLOPE_NONE = 2'd0,
    SLOPE_UP   = 2'd1,
    SLOPE_DOWN = 2'd2
  } slope_e;
endpackage

// File: rtl/pfx_timing.sv
module pfx_timing #(
  parameter int W  = 12,
  parameter int CW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                first,
  input  logic signed [W-1:0] sample,
  input  logic signed [W-1:0] thr,
  input  logic [CW-1:0]       idx,
  output logic [CW-1:0]       tcross,
  output logic [CW-1:0]       tot,
  output logic                nohit,
  output logic                ovf
);
  logic          hit_q, run_q;
  logic [CW-1:0] tc_q, tot_q;
  logic          hit_p, run_p, hit_n, run_n, over;
  logic [CW-1:0] tc_p, tot_p, tc_n, tot_n;

  always_comb begin
    hit_p = first ? 1'b0 : hit_q;
    run_p = first ? 1'b0 : run_q;
    tc_p  = first ? '0 : tc_q;
    tot_p = first ? '0 : tot_q;
    over  = sample > thr;
    hit_n = hit_p;
    run_n = run_p;
    tc_n  = tc_p;
    tot_n = tot_p;
    if (!hit_p) begin
      if (over) begin
        hit_n = 1'b1;
        run_n = 1'b1;
        tc_n  = idx;
        tot_n = CW'(1);
      end
    end else if (run_p) begin
      if (over) begin
        if (tot_p != '1) tot_n = tot_p + CW'(1);
      end else begin
        run_n = 1'b0;
      end
    end
  end

  assign tcross = tc_n;
  assign tot    = tot_n;
  assign nohit  = !hit_n;
  assign ovf    = run_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      run_q <= 1'b0;
      tc_q  <= '0;
      tot_q <= '0;
    end else if (step) begin
      hit_q <= hit_n;
      run_q <= run_n;
      tc_q  <= tc_n;
      tot_q <= tot_n;
    end
  end
endmodule

// File: rtl/pfx_slope.sv
module pfx_slope
  import pfx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                first,
  input  logic signed [W-1:0] sample,
  input  logic signed [W-1:0] thr,
  input  logic [W-1:0]        deadband,
  output logic                pileup
);
  logic signed [W-1:0] prev_q;
  slope_e              dir_q, dir_n;
  logic [1:0]          cnt_q, cnt_n;
  logic signed [W+1:0] diff, band;
  logic                rising, falling;

  always_comb begin
    diff    = $signed({{2{sample[W-1]}}, sample}) - $signed({{2{prev_q[W-1]}}, prev_q});
    band    = $signed({2'b00, deadband});
    rising  = diff > band;
    falling = diff < -band;
    if (first) begin
      dir_n = SLOPE_NONE;
      cnt_n = 2'd0;
    end else begin
      cnt_n = cnt_q;
      if (falling && dir_q == SLOPE_UP && prev_q > thr && cnt_q != 2'd3)
        cnt_n = cnt_q + 2'd1;
      if (rising)       dir_n = SLOPE_UP;
      else if (falling) dir_n = SLOPE_DOWN;
      else              dir_n = dir_q;
    end
  end

  assign pileup = cnt_n >= 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      dir_q  <= SLOPE_NONE;
      cnt_q  <= 2'd0;
    end else if (step) begin
      prev_q <= sample;
      dir_q  <= dir_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/pfx_integ.sv
module pfx_integ #(
  parameter int W  = 12,
  parameter int CW = 11,
  parameter int AW = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 first,
  input  logic signed [W-1:0]  sample,
  input  logic [CW-1:0]        idx,
  input  logic [CW-1:0]        win_start,
  input  logic [CW-1:0]        win_len,
  output logic signed [AW-1:0] charge
);
  logic signed [AW-1:0] acc_q, acc_p, addend;
  logic [CW:0]          win_end;
  logic                 in_win;

  always_comb begin
    win_end = {1'b0, win_start} + {1'b0, win_len};
    in_win  = ({1'b0, idx} >= {1'b0, win_start}) && ({1'b0, idx} < win_end);
    addend  = in_win ? {{(AW-W){sample[W-1]}}, sample} : '0;
    acc_p   = first ? '0 : acc_q;
    charge  = acc_p + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= charge;
  end
endmodule

// File: rtl/pulse_feature_unit.sv
module pulse_feature_unit #(
  parameter  int W       = 12,
  parameter  int MAX_LEN = 1024,
  localparam int CW      = $clog2(MAX_LEN + 1),
  localparam int AW      = W + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W-1:0]  in_sample,
  input  logic                 in_last,
  input  logic signed [W-1:0]  cfg_thr,
  input  logic [W-1:0]         cfg_deadband,
  input  logic [CW-1:0]        cfg_win_start,
  input  logic [CW-1:0]        cfg_win_len,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic signed [AW-1:0] res_charge,
  output logic [CW-1:0]        res_tcross,
  output logic [CW-1:0]        res_tot,
  output logic                 res_pileup,
  output logic                 res_nohit,
  output logic                 res_ovf
);
  logic          fire, first_q;
  logic [CW-1:0] idx_q, idx_cur;
  logic signed [AW-1:0] charge_w;
  logic [CW-1:0] tcross_w, tot_w;
  logic          nohit_w, ovf_w, pileup_w;

  assign in_ready = !res_valid;
  assign fire     = in_valid && in_ready;
  assign idx_cur  = first_q ? '0 : ((idx_q == '1) ? idx_q : idx_q + CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      idx_q   <= '0;
    end else if (fire) begin
      first_q <= in_last;
      idx_q   <= idx_cur;
    end
  end

  pfx_timing #(.W(W), .CW(CW)) u_timing (
    .clk(clk), .rst_n(rst_n), .step(fire), .first(first_q),
    .sample(in_sample), .thr(cfg_thr), .idx(idx_cur),
    .tcross(tcross_w), .tot(tot_w), .nohit(nohit_w), .ovf(ovf_w)
  );

  pfx_slope #(.W(W)) u_slope (
    .clk(clk), .rst_n(rst_n), .step(fire), .first(first_q),
    .sample(in_sample), .thr(cfg_thr), .deadband(cfg_deadband),
    .pileup(pileup_w)
  );

  pfx_integ #(.W(W), .CW(CW), .AW(AW)) u_integ (
    .clk(clk), .rst_n(rst_n), .step(fire), .first(first_q),
    .sample(in_sample), .idx(idx_cur), .win_start(cfg_win_start),
    .win_len(cfg_win_len), .charge(charge_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_charge <= '0;
      res_tcross <= '0;
      res_tot    <= '0;
      res_pileup <= 1'b0;
      res_nohit  <= 1'b0;
      res_ovf    <= 1'b0;
    end else if (fire && in_last) begin
      res_valid  <= 1'b1;
      res_charge <= charge_w;
      res_tcross <= tcross_w;
      res_tot    <= tot_w;
      res_pileup <= pileup_w;
      res_nohit  <= nohit_w;
      res_ovf    <= ovf_w;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int W  = 12,
  parameter int CW = 11,
  parameter int AW = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_last,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic signed [AW-1:0] res_charge,
  input logic [CW-1:0]        res_tcross,
  input logic [CW-1:0]        res_tot,
  input logic                 res_pileup,
  input logic                 res_nohit,
  input logic                 res_ovf
);
  AST_PENDING_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready); // R1

  AST_RECORD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> res_valid); // R1

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_charge) && $stable(res_tcross)
      && $stable(res_tot) && $stable(res_pileup) && $stable(res_nohit) && $stable(res_ovf))); // R1

  AST_NOHIT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nohit) |-> (res_tcross == '0 && res_tot == '0 && !res_ovf)); // R5

  AST_HIT_HAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_nohit) |-> (res_tot != '0)); // R4

  AST_OVF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> !res_nohit); // R6

  AST_PILEUP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pileup) |-> !res_nohit); // R7
endmodule

bind pulse_feature_unit pfx_checker #(.W(W), .CW(CW), .AW(AW)) u_pfx_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .res_valid(res_valid), .res_ready(res_ready),
  .res_charge(res_charge), .res_tcross(res_tcross), .res_tot(res_tot),
  .res_pileup(res_pileup), .res_nohit(res_nohit), .res_ovf(res_ovf)
);

// File: tb/pulse_feature_unit_test.sv
module pulse_feature_unit_test;
  localparam int W  = 12;
  localparam int ML = 1024;
  localparam int CW = $clog2(ML + 1);
  localparam int AW = W + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, res_ready = 1'b0;
  logic signed [W-1:0] in_sample = '0, cfg_thr = '0;
  logic [W-1:0]  cfg_deadband = '0;
  logic [CW-1:0] cfg_win_start = '0, cfg_win_len = '0;
  logic in_ready, res_valid, res_pileup, res_nohit, res_ovf;
  logic signed [AW-1:0] res_charge;
  logic [CW-1:0] res_tcross, res_tot;

  always #5 clk = ~clk;

  pulse_feature_unit #(.W(W), .MAX_LEN(ML)) uut (.*);

  int tests = 0, fails = 0;
  int samp [0:255];
  int nsamp;
  int thr, band, wst, wlen;
  int e_charge, e_tc, e_tot, e_pile, e_nohit, e_ovf;

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int shape(int k, int amp);
    if (k < 3) return amp * (k + 1) / 3;
    if (k < 13) return amp - (k - 2) * amp / 11;
    return 0;
  endfunction

  task automatic baseline(input int n);
    nsamp = n;
    for (int i = 0; i < n; i++) samp[i] = int'($urandom % 7) - 3;
  endtask

  task automatic add_pulse(input int pos, input int amp);
    for (int i = pos; i < nsamp; i++) samp[i] += shape(i - pos, amp);
  endtask

  task automatic model();
    int dir, peaks, d, run;
    e_charge = 0; e_tc = 0; e_tot = 0; e_nohit = 1; e_ovf = 0;
    dir = 0; peaks = 0; run = 0;
    for (int i = 0; i < nsamp; i++) begin
      if (i >= wst && i < wst + wlen) e_charge += samp[i];
      if (e_nohit == 1) begin
        if (samp[i] > thr) begin e_nohit = 0; e_tc = i; e_tot = 1; run = 1; end
      end else if (run == 1) begin
        if (samp[i] > thr) e_tot++; else run = 0;
      end
      if (i > 0) begin
        d = samp[i] - samp[i-1];
        if (d < -band && dir == 1 && samp[i-1] > thr) peaks++;
        if (d > band) dir = 1; else if (d < -band) dir = 2;
      end
    end
    e_ovf  = run;
    e_pile = (peaks >= 2) ? 1 : 0;
  endtask

  task automatic run_window(input int stall, input int gaps);
    logic signed [AW-1:0] h_charge;
    logic [CW-1:0] h_tot;
    model();
    @(negedge clk);
    cfg_thr = thr[W-1:0]; cfg_deadband = band[W-1:0];
    cfg_win_start = wst[CW-1:0]; cfg_win_len = wlen[CW-1:0];
    for (int i = 0; i < nsamp; i++) begin
      if (gaps != 0) begin
        in_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
      end
      in_valid = 1'b1; in_sample = samp[i][W-1:0]; in_last = (i == nsamp - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R1 record valid after last", res_valid, 1);
    chk("R1 input stalled while pending", in_ready, 0);
    h_charge = res_charge; h_tot = res_tot;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R1 record held", (res_valid && res_charge == h_charge && res_tot == h_tot), 1);
      chk("R1 ready low during stall", in_ready, 0);
    end
    chk("R2 charge", longint'(res_charge), e_charge);
    chk("R3 crossing", res_tcross, e_tc);
    chk("R4 time over threshold", res_tot, e_tot);
    chk("R5 nohit", res_nohit, e_nohit);
    chk("R6 overflow", res_ovf, e_ovf);
    chk("R7 pileup", res_pileup, e_pile);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R1 ready after take", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset in_ready", in_ready, 1);
    chk("R9 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    thr = 100; band = 8; wst = 0; wlen = 255;
    // R3 R4 single isolated pulse
    baseline(40); add_pulse(10, 500); run_window(0, 0);
    // R7 two separated pulses
    baseline(45); add_pulse(5, 400); add_pulse(25, 400); run_window(2, 1);
    // R5 baseline only
    baseline(20); run_window(0, 0);
    // R6 pulse cut off at window end
    baseline(30); add_pulse(26, 600); run_window(1, 0);
    // R8 ramp with small dips: one peak with dead band, two without
    nsamp = 12;
    samp[0] = 0; samp[1] = 50; samp[2] = 150; samp[3] = 250; samp[4] = 245; samp[5] = 350;
    samp[6] = 450; samp[7] = 440; samp[8] = 300; samp[9] = 150; samp[10] = 50; samp[11] = 0;
    run_window(0, 0);
    chk("R8 dead band hides ripple", res_pileup, 0);
    band = 0; run_window(0, 0);
    band = 8;
    // R3 strict threshold: equal sample is not a crossing
    baseline(10); samp[3] = 100; samp[6] = 101; run_window(0, 0);
    // R2 narrow and empty sub-windows
    baseline(30); add_pulse(3, 300); wst = 5; wlen = 4; run_window(0, 0);
    wlen = 0; run_window(0, 1);
    // R10 random windows back to back
    for (int r = 0; r < 40; r++) begin
      baseline(16 + int'($urandom % 100));
      add_pulse(int'($urandom % nsamp), 50 + int'($urandom % 850));
      if ($urandom % 2 == 1) add_pulse(int'($urandom % nsamp), 50 + int'($urandom % 850));
      band = int'($urandom % 16);
      wst = int'($urandom % 20); wlen = int'($urandom % 120);
      run_window(int'($urandom % 3), int'($urandom % 2));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule